// File: doc/BRIEF.md
# Rename Tag Token Pool

This block keeps the pool of free rename tags for an out-of-order core's dispatch stage. It is a circular queue whose storage holds one tag per slot. Reset does not leave it empty: every slot is loaded with a different tag value, so the pool holds every tag and reports full from the first cycle. The dispatch stage takes a tag for each new destination register from the head of the queue. When an instruction completes and its tag is no longer needed, the tag is written back at the tail.

Tags come back in whatever order instructions finish. The queue order therefore means nothing beyond where a tag is stored, and the pool acts as a token box. The head tag is visible on `pop_tag` whenever the pool is not empty. A pop takes effect at the next clock edge. When the pool is empty, dispatch has to stall. A return and a take in the same cycle are allowed, and then the number of free tags stays the same.

Top module: `tagpool_fifo`

## Requirements
- R1: After reset the pool reports full=1 and empty=0, and `pop_tag` shows tag 0 (with the default ascending preload).
- R2: Starting from reset, pops with no returns give tags 0, 1, 2, … 63 in ascending order. Each tag appears once. After the 64th pop the pool is empty.
- R3: While empty=0, `pop_tag` shows the head tag. A pop accepted at a clock edge presents the next stored tag after that edge.
- R4: A pop request while the pool is empty is ignored. Empty stays 1, and no tag is consumed.
- R5: A return request while the pool is full and no pop is requested is ignored. Full stays 1, and the sequence of tags popped afterwards is unchanged.
- R6: Returned tags can have any value and arrive in any order. They are popped in the order they were returned, after the tags already stored.
- R7: A pop and a return in the same cycle while the pool is neither empty nor full leave full and empty unchanged.
- R8: A pop and a return in the same cycle while the pool is full are both accepted, and the pool stays full.
- R9: A pop and a return in the same cycle while the pool is empty accept only the return. After that edge empty=0 and `pop_tag` equals the returned tag.
- R10: Empty is 1 exactly when 0 tags are held, and full is 1 exactly when 64 tags are held. The two are never 1 together.
- R11: Both pointers wrap circularly. The queue order stays correct through many more than 64 operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; preloads every tag |
| pop_req | input | 1 | Dispatch takes the head tag this cycle |
| pop_tag | output | 6 | Head tag; valid while empty=0 |
| empty | output | 1 | No free tag held; dispatch must stall |
| push_req | input | 1 | A completed instruction returns a tag |
| push_tag | input | 6 | Tag being returned |
| full | output | 1 | All 64 tags held; a lone return is refused |

## Verification
The hardest case to reach is a return and a take in the same cycle at either extreme of occupancy. The pool leaves reset full, so it has to be drained through all 64 tags before the empty cases can be tested, and then filled again before the full cases can be tested. The stimulus first drains the pool completely and applies the empty-state corner cases. It then returns a scrambled set of tags until the pool is full and applies the full-state corner cases. A long pseudo-random mix of takes and returns follows, which wraps both pointers many times. Every cycle is compared against a queue model.

// File: rtl/tagpool_pkg.sv
package tagpool_pkg;

   // Which tag value each slot receives at reset
   typedef enum logic {
      PRELOAD_ASCEND  = 1'b0,
      PRELOAD_DESCEND = 1'b1
   } preload_e;

   // Width of a pointer that carries one extra lap bit
   function automatic int unsigned lap_ptr_width(input int unsigned idx_w);
      return idx_w + 1;
   endfunction

endpackage

// File: rtl/tagpool_ptr.sv
module tagpool_ptr #(
   parameter int unsigned IDX_W     = 6,
   parameter bit          RESET_LAP = 1'b0,
   localparam int unsigned PTR_W    = tagpool_pkg::lap_ptr_width(IDX_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [PTR_W-1:0] ptr
);

   localparam logic [PTR_W-1:0] RST_VAL = {RESET_LAP, {IDX_W{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ptr <= RST_VAL;
      else if (adv) ptr <= ptr + PTR_W'(1);
   end

   // R11
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (ptr == $past(ptr)) || (ptr == $past(ptr) + PTR_W'(1)));

endmodule

// File: rtl/tagpool_store.sv
module tagpool_store #(
   parameter int unsigned          TAG_W = 6,
   parameter int unsigned          DEPTH = 64,
   parameter tagpool_pkg::preload_e ORDER = tagpool_pkg::PRELOAD_ASCEND,
   localparam int unsigned         IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [TAG_W-1:0] rd_data
);

   logic [DEPTH-1:0][TAG_W-1:0] slot_q;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [TAG_W-1:0] q;
      logic [TAG_W-1:0] init_val;

      if (ORDER == tagpool_pkg::PRELOAD_DESCEND) begin : g_desc
         assign init_val = TAG_W'(DEPTH - 1 - i);
      end else begin : g_asc
         assign init_val = TAG_W'(i);
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             q <= init_val;
         else if (wr_en && wr_idx == IDX_W'(i))  q <= wr_data;
      end

      assign slot_q[i] = q;
   end

   assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/tagpool_flags.sv
module tagpool_flags #(
   parameter int unsigned IDX_W = 6,
   localparam int unsigned PTR_W = tagpool_pkg::lap_ptr_width(IDX_W),
   localparam int unsigned DEPTH = 1 << IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PTR_W-1:0] wr_ptr,
   input  logic [PTR_W-1:0] rd_ptr,
   output logic [PTR_W-1:0] occ,
   output logic             full,
   output logic             empty
);

   localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

   assign occ   = wr_ptr - rd_ptr;
   assign full  = (occ == DEPTH_P);
   assign empty = (occ == '0);

   // R10
   occ_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= DEPTH_P);

endmodule

// File: rtl/tagpool_fifo.sv
module tagpool_fifo #(
   parameter int unsigned           TAG_W = 6,
   parameter int unsigned           DEPTH = 64,
   parameter tagpool_pkg::preload_e ORDER = tagpool_pkg::PRELOAD_ASCEND
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pop_req,
   output logic [TAG_W-1:0] pop_tag,
   output logic             empty,
   input  logic             push_req,
   input  logic [TAG_W-1:0] push_tag,
   output logic             full
);

   localparam int unsigned IDX_W = $clog2(DEPTH);
   localparam int unsigned PTR_W = tagpool_pkg::lap_ptr_width(IDX_W);

   if (DEPTH != (1 << TAG_W)) begin : g_bad_depth
      $error("tagpool_fifo: DEPTH must equal 2**TAG_W so every tag has a slot");
   end
   if (TAG_W < 1) begin : g_bad_width
      $error("tagpool_fifo: TAG_W must be at least 1");
   end

   logic [PTR_W-1:0] wr_ptr, rd_ptr, occ;
   logic             pop_ok, push_ok;

   // A return is accepted on full only when a take frees a slot in the same cycle
   assign pop_ok  = pop_req && !empty;
   assign push_ok = push_req && (!full || pop_req);

   tagpool_ptr #(.IDX_W(IDX_W), .RESET_LAP(1'b0)) u_rd_ptr (
      .clk (clk), .rst_n (rst_n), .adv (pop_ok),  .ptr (rd_ptr)
   );

   tagpool_ptr #(.IDX_W(IDX_W), .RESET_LAP(1'b1)) u_wr_ptr (
      .clk (clk), .rst_n (rst_n), .adv (push_ok), .ptr (wr_ptr)
   );

   tagpool_store #(.TAG_W(TAG_W), .DEPTH(DEPTH), .ORDER(ORDER)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (push_ok),
      .wr_idx  (wr_ptr[IDX_W-1:0]),
      .wr_data (push_tag),
      .rd_idx  (rd_ptr[IDX_W-1:0]),
      .rd_data (pop_tag)
   );

   tagpool_flags #(.IDX_W(IDX_W)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_ptr (wr_ptr),
      .rd_ptr (rd_ptr),
      .occ    (occ),
      .full   (full),
      .empty  (empty)
   );

   // R10
   full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty));

   // R4
   pop_empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop_req && !push_req) |=> empty);

   // R5
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push_req && !pop_req) |=> (full && $stable(pop_tag)));

   // R8
   full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push_req && pop_req) |=> full);

   // R9
   empty_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && push_req) |=> (!empty && pop_tag == $past(push_tag)));

   // R7
   swap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!empty && !full && push_req && pop_req) |=> $stable(occ));

endmodule

// File: tb/sim_tagpool_fifo.sv
module sim_tagpool_fifo;

   localparam int TAG_W = 6;
   localparam int DEPTH = 64;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             pop_req = 1'b0;
   logic             push_req = 1'b0;
   logic [TAG_W-1:0] push_tag = '0;
   logic [TAG_W-1:0] pop_tag;
   logic             empty, full;

   int    n_cmp = 0;
   int    n_bad = 0;
   int    q[$];
   string cur_req = "R1";
   bit    done = 1'b0;

   always #2.5 clk = ~clk;

   tagpool_fifo #(.TAG_W(TAG_W), .DEPTH(DEPTH)) u0 (
      .clk (clk), .rst_n (rst_n),
      .pop_req (pop_req), .pop_tag (pop_tag), .empty (empty),
      .push_req (push_req), .push_tag (push_tag), .full (full)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Compare the ports against the queue model; flags are R10 in every phase
   task automatic compare();
      chk(cur_req, "empty", int'(empty), int'(q.size() == 0));
      chk(cur_req, "full",  int'(full),  int'(q.size() == DEPTH));
      if (q.size() != 0) chk(cur_req, "pop_tag", int'(pop_tag), q[0]);
   endtask

   // Drive at the falling edge, update the model at the rising edge, sample at the next falling edge
   task automatic step(input bit p, input bit u, input int t);
      bit pop_ok, push_ok;
      pop_req  = p;
      push_req = u;
      push_tag = TAG_W'(t);
      @(posedge clk);
      pop_ok  = p && (q.size() != 0);
      push_ok = u && ((q.size() < DEPTH) || p);
      if (pop_ok)  void'(q.pop_front());
      if (push_ok) q.push_back(t & (DEPTH - 1));
      @(negedge clk);
      pop_req  = 1'b0;
      push_req = 1'b0;
      compare();
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int unsigned lfsr;
      for (int i = 0; i < DEPTH; i++) q.push_back(i);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state, full of tags, head tag 0
      cur_req = "R1";
      compare();

      // R3: the first takes present the next tag after each edge
      cur_req = "R3";
      for (int i = 0; i < 4; i++) step(1, 0, 0);
      // R2: drain the rest in ascending order until empty
      cur_req = "R2";
      for (int i = 4; i < DEPTH; i++) step(1, 0, 0);
      chk("R2", "empty after 64 takes", int'(empty), 1);

      // R4: takes while empty are ignored
      cur_req = "R4";
      for (int i = 0; i < 3; i++) step(1, 0, 0);

      // R9: take plus return while empty keeps only the return
      cur_req = "R9";
      step(1, 1, 45);
      chk("R9", "pop_tag after return on empty", int'(pop_tag), 45);

      // R6: scrambled returns come back in return order
      cur_req = "R6";
      step(0, 1, 17);
      step(0, 1, 3);
      step(0, 1, 60);
      step(0, 1, 9);

      // R7: take and return together in the middle of the range
      cur_req = "R7";
      step(1, 1, 22);
      step(1, 1, 51);
      step(1, 1, 0);

      // R6: drain back out in order
      cur_req = "R6";
      for (int i = 0; i < 4; i++) step(1, 0, 0);

      // R10: refill to full with scrambled tags
      cur_req = "R10";
      while (q.size() < DEPTH) step(0, 1, (q.size() * 37 + 11) % DEPTH);
      chk("R10", "full after refill", int'(full), 1);

      // R5: a lone return while full is ignored
      cur_req = "R5";
      step(0, 1, 63);
      step(0, 1, 1);

      // R8: take plus return while full keeps it full
      cur_req = "R8";
      step(1, 1, 33);
      step(1, 1, 34);
      chk("R8", "full after swap", int'(full), 1);

      // R11: long mixed traffic, wrapping both pointers many times
      cur_req = "R11";
      lfsr = 32'hACE1_1357;
      for (int i = 0; i < 600; i++) begin
         lfsr = lfsr ^ (lfsr << 13);
         lfsr = lfsr ^ (lfsr >> 17);
         lfsr = lfsr ^ (lfsr << 5);
         step(lfsr[0] | lfsr[7], lfsr[3] | lfsr[9], int'(lfsr[21:16]));
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule